// File: doc/BRIEF.md
# Shift-Coefficient DC Offset Remover

This block strips the constant offset from a stream of signed two's-complement samples. A first-order recursive low-pass tracker keeps a running estimate of the offset. Each accepted sample has the current estimate subtracted from it, and then the tracker is updated. The result is a first-order high-pass response with a transmission zero at zero frequency.

The pole is set by a right shift of `SHIFT_K` bits, so the tracker uses no multiplier. A larger shift gives a lower corner frequency and a slower settling time. The estimate keeps `SHIFT_K` fractional bits. The low bits that each shift drops are stored in a small remainder register and added into the next update, so truncation does not leave a standing error.

Samples arrive with a valid strobe and leave one clock later with a matching strobe. Cycles without a valid sample leave all state untouched.

Top module: `dc_blocker`

## Requirements
- R1: A synchronous active-high `rst` clears the estimate and the remainder to zero, drives `out_valid` low and sets `out_sample` to zero.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock.
- R3: An accepted sample x leaves one clock later as x minus the integer part (floor) of the estimate held before that sample's update. No extra sample delay is applied.
- R4: Estimate E is held with `SHIFT_K` fractional bits. Remainder r is an unsigned `SHIFT_K`-bit value. An accepted sample x forms s = x*2^K - E + r. Then E becomes E + floor(s / 2^K) and r becomes the low K bits of s.
- R5: A constant input, positive or negative, drives the output to exactly zero. No residual of one LSB may remain.
- R6: When `in_valid` is low, the estimate and the remainder are unchanged, `out_valid` is low the next cycle, and `out_sample` holds its previous value.
- R7: A difference above 2^(DATA_W-1)-1 gives `out_sample` = 2^(DATA_W-1)-1. A difference below -2^(DATA_W-1) gives -2^(DATA_W-1).
- R8: The estimate never overshoots the input. After a step up from a settled estimate, every output stays between zero and the step height.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_sample` as a sample to process |
| in_sample | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Marks `out_sample` as a result |
| out_sample | output | DATA_W | Signed, offset-removed, saturated sample |

## Verification
The sharpest case is a long run of a constant positive value. If the design truncates without keeping the remainder, its estimate stalls one LSB short and the output settles at 1 instead of 0. A negative constant settles to zero either way, so both signs are run. The bench drives the estimate to one rail and then steps the input to the other rail. A design that wraps instead of clamping shows a sign flip at that point. A design that uses the updated estimate shows a value shifted by one update. Gaps in `in_valid` show whether idle cycles disturb the state, and a reset in the middle of a run shows whether the estimate really clears.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

  // Classification of the raw difference against the output range.
  typedef enum logic [1:0] {
    SAT_NONE = 2'b00,
    SAT_HIGH = 2'b01,
    SAT_LOW  = 2'b10
  } sat_e;

  // Number of extra integer headroom bits used by the tracker sum.
  localparam int unsigned SUM_GUARD = 2;

endpackage

// File: rtl/dcb_estimator.sv
module dcb_estimator #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SHIFT_K    = 4,
  parameter bit          KEEP_REM   = 1'b1,
  localparam int unsigned EST_W     = DATA_W + SHIFT_K,
  localparam int unsigned SUM_W     = EST_W + dcb_pkg::SUM_GUARD
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     take,
  input  logic signed [DATA_W-1:0] sample,
  output logic signed [EST_W-1:0]  est_q,
  output logic        [SHIFT_K-1:0] rem_q,
  output logic signed [DATA_W-1:0] est_whole
);

  // Align the sample onto the fixed-point grid of the estimate.
  function automatic logic signed [SUM_W-1:0] widen_sample(
    input logic signed [DATA_W-1:0] v
  );
    logic signed [SUM_W-1:0] t;
    t = SUM_W'(v);
    return t <<< SHIFT_K;
  endfunction

  // Error term plus the remainder carried from the previous update.
  function automatic logic signed [SUM_W-1:0] error_sum(
    input logic signed [DATA_W-1:0]  v,
    input logic signed [EST_W-1:0]   e,
    input logic        [SHIFT_K-1:0] r
  );
    logic signed [SUM_W-1:0] re;
    re = $signed({{(SUM_W-SHIFT_K){1'b0}}, r});
    return widen_sample(v) - SUM_W'(e) + re;
  endfunction

  logic signed [SUM_W-1:0]   sum_w;
  logic signed [EST_W-1:0]   step_w;
  logic signed [EST_W-1:0]   est_next;
  logic        [SHIFT_K-1:0] rem_next;

  assign sum_w    = error_sum(sample, est_q, rem_q);
  assign step_w   = EST_W'(sum_w >>> SHIFT_K);
  assign est_next = est_q + step_w;

  generate
    if (KEEP_REM) begin : g_keep
      assign rem_next = sum_w[SHIFT_K-1:0];
    end else begin : g_drop
      assign rem_next = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      est_q <= '0;
      rem_q <= '0;
    end else if (take) begin
      est_q <= est_next;
      rem_q <= rem_next;
    end
  end

  // Integer part of the estimate, rounded toward minus infinity.
  assign est_whole = est_q[EST_W-1:SHIFT_K];

endmodule

// File: rtl/dcb_out_stage.sv
module dcb_out_stage #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned DIFF_W = DATA_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     take,
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [DATA_W-1:0] est_whole,
  output logic                     sat_hi,
  output logic                     sat_lo,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_sample
);
  import dcb_pkg::*;

  localparam logic signed [DIFF_W-1:0] TOP_V = DIFF_W'((1 <<< (DATA_W-1)) - 1);
  localparam logic signed [DIFF_W-1:0] BOT_V = -DIFF_W'(1 <<< (DATA_W-1));

  function automatic sat_e classify(input logic signed [DIFF_W-1:0] d);
    if (d > TOP_V)      return SAT_HIGH;
    else if (d < BOT_V) return SAT_LOW;
    else                return SAT_NONE;
  endfunction

  function automatic logic signed [DATA_W-1:0] clamp(
    input logic signed [DIFF_W-1:0] d,
    input sat_e                     c
  );
    case (c)
      SAT_HIGH: return TOP_V[DATA_W-1:0];
      SAT_LOW:  return BOT_V[DATA_W-1:0];
      default:  return d[DATA_W-1:0];
    endcase
  endfunction

  logic signed [DIFF_W-1:0] diff_w;
  sat_e                     cls_w;

  assign diff_w = DIFF_W'(sample) - DIFF_W'(est_whole);
  assign cls_w  = classify(diff_w);
  assign sat_hi = take && (cls_w == SAT_HIGH);
  assign sat_lo = take && (cls_w == SAT_LOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= take;
      if (take) out_sample <= clamp(diff_w, cls_w);
    end
  end

endmodule

// File: rtl/dc_blocker.sv
module dc_blocker #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned SHIFT_K  = 4,
  parameter bit          KEEP_REM = 1'b1,
  localparam int unsigned EST_W   = DATA_W + SHIFT_K
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_sample
);

  logic signed [EST_W-1:0]   est_q;
  logic        [SHIFT_K-1:0] rem_q;
  logic signed [DATA_W-1:0]  est_whole;
  logic                      sat_hi;
  logic                      sat_lo;

  dcb_estimator #(
    .DATA_W   (DATA_W),
    .SHIFT_K  (SHIFT_K),
    .KEEP_REM (KEEP_REM)
  ) u_est (
    .clk       (clk),
    .rst       (rst),
    .take      (in_valid),
    .sample    (in_sample),
    .est_q     (est_q),
    .rem_q     (rem_q),
    .est_whole (est_whole)
  );

  dcb_out_stage #(
    .DATA_W (DATA_W)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .take       (in_valid),
    .sample     (in_sample),
    .est_whole  (est_whole),
    .sat_hi     (sat_hi),
    .sat_lo     (sat_lo),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

endmodule

// File: rtl/dcb_checker.sv
module dcb_checker #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SHIFT_K = 4,
  localparam int unsigned EST_W  = DATA_W + SHIFT_K,
  localparam int unsigned CMP_W  = EST_W + 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in_sample,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_sample,
  input logic signed [EST_W-1:0]  est_q,
  input logic        [SHIFT_K-1:0] rem_q,
  input logic signed [DATA_W-1:0] est_whole,
  input logic                     sat_hi,
  input logic                     sat_lo
);

  localparam logic signed [DATA_W-1:0] TOP_S = DATA_W'((1 <<< (DATA_W-1)) - 1);
  localparam logic signed [DATA_W-1:0] BOT_S = -DATA_W'(1 <<< (DATA_W-1));

  logic signed [CMP_W-1:0]  x_grid;
  logic signed [CMP_W-1:0]  e_grid;
  logic signed [DATA_W:0]   raw_diff;

  assign x_grid   = CMP_W'(in_sample) <<< SHIFT_K;
  assign e_grid   = CMP_W'(est_q);
  assign raw_diff = (DATA_W+1)'(in_sample) - (DATA_W+1)'(est_whole);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (est_q == '0 && rem_q == '0 && !out_valid && out_sample == '0));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_same_index_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sat_hi && !sat_lo) |=>
      ((DATA_W+1)'(out_sample) == $past(raw_diff)));

  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(est_q) && $stable(rem_q) && $stable(out_sample)));

  assert_clamp_high_R7: assert property (@(posedge clk) disable iff (rst)
    sat_hi |=> (out_sample == TOP_S));

  assert_clamp_low_R7: assert property (@(posedge clk) disable iff (rst)
    sat_lo |=> (out_sample == BOT_S));

  assert_no_overshoot_up_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && e_grid <= x_grid) |=> (CMP_W'(est_q) <= $past(x_grid)));

  assert_no_overshoot_dn_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && e_grid >= x_grid) |=> (CMP_W'(est_q) >= $past(x_grid)));

  assert_sat_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(sat_hi && sat_lo));

endmodule

bind dc_blocker dcb_checker #(
  .DATA_W  (DATA_W),
  .SHIFT_K (SHIFT_K)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_sample  (in_sample),
  .out_valid  (out_valid),
  .out_sample (out_sample),
  .est_q      (est_q),
  .rem_q      (rem_q),
  .est_whole  (est_whole),
  .sat_hi     (sat_hi),
  .sat_lo     (sat_lo)
);

// File: tb/tb_dc_blocker.sv
module tb_dc_blocker;

  localparam int DW       = 16;
  localparam int K        = 4;
  localparam int CLK_PER  = 10;
  localparam int WATCHDOG = 150000;
  localparam longint TOPV = 32767;
  localparam longint BOTV = -32768;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_sample = '0;
  logic                 out_valid;
  logic signed [DW-1:0] out_sample;

  int nvec  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  // Independent model state: estimate in 1/2^K units and carried remainder.
  longint m_est = 0;
  longint m_rem = 0;

  // Stimulus table: {valid, sample}.
  localparam logic [DW:0] VEC [0:19] = '{
    17'h1_0064, 17'h1_0064, 17'h1_00C8, 17'h1_FF38, 17'h0_1234,
    17'h1_7000, 17'h1_8000, 17'h1_0000, 17'h0_0000, 17'h1_0001,
    17'h1_FFFF, 17'h1_03E8, 17'h1_03E8, 17'h1_FC18, 17'h0_7FFF,
    17'h1_0010, 17'h1_1000, 17'h1_F000, 17'h1_0007, 17'h1_FFF9
  };

  dc_blocker #(.DATA_W(DW), .SHIFT_K(K)) dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; drives one cycle and checks at the next falling edge.
  task automatic drive(input bit v, input logic signed [DW-1:0] x, input string req);
    longint exp_o;
    longint s;
    longint st;
    exp_o = 0;
    in_valid  = v;
    in_sample = x;
    if (v) begin
      exp_o = longint'(x) - (m_est >>> K);
      if (exp_o > TOPV) exp_o = TOPV;
      if (exp_o < BOTV) exp_o = BOTV;
      s     = (longint'(x) <<< K) - m_est + m_rem;
      st    = s >>> K;
      m_rem = s - (st <<< K);
      m_est = m_est + st;
    end
    @(negedge clk);
    check(out_valid == v, "R2", longint'(out_valid), longint'(v));
    if (v) check(longint'(out_sample) == exp_o, req, longint'(out_sample), exp_o);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    m_est = 0;
    m_rem = 0;
    check(out_valid == 1'b0, "R1", longint'(out_valid), 0);
    check(out_sample == '0, "R1", longint'(out_sample), 0);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nvec++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin : main
    logic signed [DW-1:0] held;
    bit ok_range;
    @(negedge clk);
    do_reset();

    // Table walk: R3/R4 arithmetic on mixed patterns, R6 gaps.
    for (int i = 0; i < 20; i++) begin
      if (VEC[i][DW]) drive(1'b1, VEC[i][DW-1:0], "R3_R4");
      else begin
        held = out_sample;
        drive(1'b0, VEC[i][DW-1:0], "R6");
        check(out_sample == held, "R6", longint'(out_sample), longint'(held));
      end
    end

    // R6: idle burst must not disturb state; next sample matches model.
    held = out_sample;
    for (int i = 0; i < 5; i++) drive(1'b0, 16'sh5555, "R6");
    check(out_sample == held, "R6", longint'(out_sample), longint'(held));
    drive(1'b1, 16'sd300, "R6");

    // R1: reset mid-run clears the estimate; first output equals input.
    do_reset();
    drive(1'b1, 16'sd500, "R1");
    check(out_sample == 16'sd500, "R1", longint'(out_sample), 500);

    // R8: step from zero estimate to 100 never under/overshoots.
    do_reset();
    ok_range = 1'b1;
    for (int i = 0; i < 60; i++) begin
      drive(1'b1, 16'sd100, "R8");
      if (out_sample < 0 || out_sample > 100) ok_range = 1'b0;
    end
    check(ok_range, "R8", longint'(out_sample), 0);

    // R5: positive constant settles to exactly zero.
    do_reset();
    for (int i = 0; i < 500; i++) drive(1'b1, 16'sd1000, "R5");
    check(out_sample == 0, "R5", longint'(out_sample), 0);

    // R5: negative constant settles to exactly zero.
    for (int i = 0; i < 500; i++) drive(1'b1, -16'sd777, "R5");
    check(out_sample == 0, "R5", longint'(out_sample), 0);

    // R7: rail-to-rail steps saturate both ways.
    for (int i = 0; i < 500; i++) drive(1'b1, -16'sd32768, "R7");
    drive(1'b1, 16'sd32767, "R7");
    check(out_sample == 16'sd32767, "R7", longint'(out_sample), TOPV);
    for (int i = 0; i < 600; i++) drive(1'b1, 16'sd32767, "R7");
    check(out_sample == 0, "R5", longint'(out_sample), 0);
    drive(1'b1, -16'sd32768, "R7");
    check(out_sample == -16'sd32768, "R7", longint'(out_sample), BOTV);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule